// File: doc/BRIEF.md
# System Reset Sequencing Controller

This block combines two reset sources into one set of reset outputs: a watchdog time-out and a software reset request. The outputs are a vector of active-high internal resets, one per downstream domain, and an active-low external reset-out pin. Both kinds of outputs are asserted and released in the same cycle.

A watchdog reset takes effect at once. A software reset takes effect only after a handshake. First the bus interconnect is asked to drain its outstanding transactions. Then the memory controller is asked to enter self-refresh. Reset is applied only after each of these steps has been acknowledged.

Once reset is applied, a down-counter loaded from a 16-bit stability register holds it for a programmed length. A two-bit cause register records which source produced the most recent reset. This register survives the reset it describes, so software can read it afterwards. The block's own `rst` input is a synchronous power-on reset. It clears the block and is never driven by the block's outputs.

Top module: `rst_seq_ctrl`

## Requirements
- R1: A watchdog expiry pulse (`wdt_expire`) produces a reset only when both `wdt_rst_en` (watchdog control bit 5) and `wdt_tmr_en` (watchdog control bit 0) are 1. With either bit at 0 the pulse is ignored.
- R2: The power mode `pmode` is encoded as 0 = normal, 1 = idle, 2 = deep idle and 3 = stop. A qualified watchdog expiry is accepted in modes 0, 1 and 2 and ignored in mode 3.
- R3: A software reset starts when `swrst_wr` is 1 with `swrst_wdata` = 1 while `pmode` = 0. A write of 0, or a write in any other mode, is ignored.
- R4: An accepted software reset raises `bus_req` in the next cycle. `bus_req` stays high, with no reset asserted, until `bus_ack` is sampled high.
- R5: In the cycle after `bus_ack`, `bus_req` falls and `sref_req` rises. `sref_req` stays high, with no reset asserted, until `sref_ack` is sampled high.
- R6: In the cycle after `sref_ack`, `sref_req` falls and the reset outputs assert. They stay asserted for exactly RELOAD+1 cycles.
- R7: A qualified watchdog expiry asserts the reset outputs in the next cycle. They stay asserted for exactly RELOAD+1 cycles.
- R8: `rst_out_n` is 0 exactly in the cycles where every bit of `int_rst` is 1. All of these outputs assert and release in the same cycle.
- R9: A write on `stab_wr` loads `stab_wdata` into the 16-bit RELOAD register, which resets to 8. The new value applies to the next reset.
- R10: If a watchdog expiry arrives in the same cycle as a software write, or during either handshake wait, the watchdog wins. The handshake requests drop and reset asserts in the next cycle.
- R11: `cause` becomes 01 (bit 0 = watchdog) or 10 (bit 1 = software) as the reset asserts. It keeps that value after the reset releases, and is cleared only by `rst`.
- R12: Watchdog expiries and software writes that arrive while reset is asserted neither lengthen the reset nor start a new sequence after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset of this block |
| wdt_expire | input | 1 | Single-cycle watchdog time-out pulse |
| wdt_rst_en | input | 1 | Watchdog reset-enable (control bit 5) |
| wdt_tmr_en | input | 1 | Watchdog timer-enable (control bit 0) |
| swrst_wr | input | 1 | Write strobe of the software-reset register |
| swrst_wdata | input | 1 | Data written to the software-reset register |
| stab_wr | input | 1 | Write strobe of the RELOAD register |
| stab_wdata | input | CNT_W | Data written to the RELOAD register |
| pmode | input | 2 | Power mode: 0 normal, 1 idle, 2 deep idle, 3 stop |
| bus_ack | input | 1 | Bus controller reports that it has drained |
| sref_ack | input | 1 | Memory controller reports that it is in self-refresh |
| bus_req | output | 1 | Request to the bus controller to drain |
| sref_req | output | 1 | Request to the memory controller to enter self-refresh |
| int_rst | output | NUM_RST | Active-high internal resets |
| rst_out_n | output | 1 | Active-low external reset-out |
| cause | output | 2 | Source of the last reset: bit 0 watchdog, bit 1 software |
| reload | output | CNT_W | Current RELOAD register value |

## Verification
The bench sweeps RELOAD from 0 upwards and measures the reset length for both sources. An off-by-one counter would show as a reset of RELOAD or RELOAD+2 cycles. The bench walks all four enable-bit combinations and all four power modes for each source. A design that decoded the enables or modes loosely would reset in stop mode or with one enable bit clear. The bench also holds off each acknowledge for several cycles and injects a watchdog expiry in each wait state. A design that skipped a handshake step would assert reset early, and one that ignored the priority rule would keep waiting. The bench re-triggers both sources during reset and checks that the cause register holds its value afterwards. Errors there show as a stretched reset, a second phantom sequence, or a lost cause.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_BUS  = 2'd1,
    ST_SREF = 2'd2,
    ST_HOLD = 2'd3
  } seq_st_t;

  localparam logic [1:0] PM_NORMAL = 2'd0;
  localparam logic [1:0] PM_IDLE   = 2'd1;
  localparam logic [1:0] PM_DEEP   = 2'd2;
  localparam logic [1:0] PM_STOP   = 2'd3;

  localparam logic [1:0] CAUSE_NONE = 2'b00;
  localparam logic [1:0] CAUSE_WDT  = 2'b01;
  localparam logic [1:0] CAUSE_SW   = 2'b10;

endpackage

// File: rtl/rst_src_qual.sv
module rst_src_qual
  import rst_seq_pkg::*;
(
  input  logic       wdt_expire,
  input  logic       wdt_rst_en,
  input  logic       wdt_tmr_en,
  input  logic       swrst_wr,
  input  logic       swrst_wdata,
  input  logic [1:0] pmode,
  output logic       wdt_fire,
  output logic       sw_fire
);

  logic wdt_mode_ok;
  logic sw_mode_ok;

  // watchdog runs on a live clock in run, idle and deep idle
  always_comb begin
    unique case (pmode)
      PM_NORMAL, PM_IDLE, PM_DEEP: wdt_mode_ok = 1'b1;
      default:                     wdt_mode_ok = 1'b0;
    endcase
  end

  assign sw_mode_ok = (pmode == PM_NORMAL);
  assign wdt_fire   = wdt_expire & wdt_rst_en & wdt_tmr_en & wdt_mode_ok;
  assign sw_fire    = swrst_wr & swrst_wdata & sw_mode_ok;

endmodule

// File: rtl/rst_stab_cnt.sv
module rst_stab_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] reload,
  output logic             done
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= ZERO;
    end else if (load) begin
      cnt_q <= reload;
    end else if (dec && cnt_q != ZERO) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign done = (cnt_q == ZERO);

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wdt_fire,
  input  logic sw_fire,
  input  logic bus_ack,
  input  logic sref_ack,
  input  logic cnt_done,
  output logic cnt_load,
  output logic cnt_dec,
  output logic enter_wdt,
  output logic enter_sw,
  output logic bus_req,
  output logic sref_req,
  output logic rst_act,
  output logic rst_out_n
);

  seq_st_t st_q;
  seq_st_t st_d;

  always_comb begin
    st_d      = st_q;
    enter_wdt = 1'b0;
    enter_sw  = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (wdt_fire) begin
          st_d      = ST_HOLD;
          enter_wdt = 1'b1;
        end else if (sw_fire) begin
          st_d = ST_BUS;
        end
      end
      ST_BUS: begin
        if (wdt_fire) begin
          st_d      = ST_HOLD;
          enter_wdt = 1'b1;
        end else if (bus_ack) begin
          st_d = ST_SREF;
        end
      end
      ST_SREF: begin
        if (wdt_fire) begin
          st_d      = ST_HOLD;
          enter_wdt = 1'b1;
        end else if (sref_ack) begin
          st_d     = ST_HOLD;
          enter_sw = 1'b1;
        end
      end
      ST_HOLD: begin
        if (cnt_done) begin
          st_d = ST_RUN;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  assign cnt_load = enter_wdt | enter_sw;
  assign cnt_dec  = (st_q == ST_HOLD);

  // outputs registered from the next state so they align with st_q
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_RUN;
      bus_req   <= 1'b0;
      sref_req  <= 1'b0;
      rst_act   <= 1'b0;
      rst_out_n <= 1'b1;
    end else begin
      st_q      <= st_d;
      bus_req   <= (st_d == ST_BUS);
      sref_req  <= (st_d == ST_SREF);
      rst_act   <= (st_d == ST_HOLD);
      rst_out_n <= (st_d != ST_HOLD);
    end
  end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int              NUM_RST     = 4,
  parameter int              CNT_W       = 16,
  parameter logic [CNT_W-1:0] RELOAD_INIT = 16'd8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wdt_expire,
  input  logic               wdt_rst_en,
  input  logic               wdt_tmr_en,
  input  logic               swrst_wr,
  input  logic               swrst_wdata,
  input  logic               stab_wr,
  input  logic [CNT_W-1:0]   stab_wdata,
  input  logic [1:0]         pmode,
  input  logic               bus_ack,
  input  logic               sref_ack,
  output logic               bus_req,
  output logic               sref_req,
  output logic [NUM_RST-1:0] int_rst,
  output logic               rst_out_n,
  output logic [1:0]         cause,
  output logic [CNT_W-1:0]   reload
);

  logic wdt_fire;
  logic sw_fire;
  logic cnt_load;
  logic cnt_dec;
  logic cnt_done;
  logic enter_wdt;
  logic enter_sw;
  logic rst_act;

  rst_src_qual u_qual (
    .wdt_expire  (wdt_expire),
    .wdt_rst_en  (wdt_rst_en),
    .wdt_tmr_en  (wdt_tmr_en),
    .swrst_wr    (swrst_wr),
    .swrst_wdata (swrst_wdata),
    .pmode       (pmode),
    .wdt_fire    (wdt_fire),
    .sw_fire     (sw_fire)
  );

  rst_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .wdt_fire  (wdt_fire),
    .sw_fire   (sw_fire),
    .bus_ack   (bus_ack),
    .sref_ack  (sref_ack),
    .cnt_done  (cnt_done),
    .cnt_load  (cnt_load),
    .cnt_dec   (cnt_dec),
    .enter_wdt (enter_wdt),
    .enter_sw  (enter_sw),
    .bus_req   (bus_req),
    .sref_req  (sref_req),
    .rst_act   (rst_act),
    .rst_out_n (rst_out_n)
  );

  rst_stab_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load   (cnt_load),
    .dec    (cnt_dec),
    .reload (reload),
    .done   (cnt_done)
  );

  // stability reload register, untouched by the resets it produces
  always_ff @(posedge clk) begin
    if (rst) begin
      reload <= RELOAD_INIT;
    end else if (stab_wr) begin
      reload <= stab_wdata;
    end
  end

  // cause register, written as a reset asserts and kept through it
  always_ff @(posedge clk) begin
    if (rst) begin
      cause <= CAUSE_NONE;
    end else if (enter_wdt) begin
      cause <= CAUSE_WDT;
    end else if (enter_sw) begin
      cause <= CAUSE_SW;
    end
  end

  for (genvar g = 0; g < NUM_RST; g++) begin : g_dom
    assign int_rst[g] = rst_act;
  end

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int NUM_RST = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               wdt_expire,
  input logic               wdt_rst_en,
  input logic               wdt_tmr_en,
  input logic [1:0]         pmode,
  input logic               bus_ack,
  input logic               sref_ack,
  input logic               bus_req,
  input logic               sref_req,
  input logic [NUM_RST-1:0] int_rst,
  input logic               rst_out_n,
  input logic [1:0]         cause
);

  logic wdt_q;
  assign wdt_q = wdt_expire && wdt_rst_en && wdt_tmr_en && (pmode != 2'd3);

  AST_WDT_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (wdt_q && !int_rst[0]) |=> int_rst[0]); // R7

  AST_SW_NORMAL_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> ($past(pmode) == 2'd0)); // R3

  AST_BUS_WAIT: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack && !wdt_q) |=> (bus_req && !int_rst[0])); // R4

  AST_SREF_AFTER_BUS: assert property (@(posedge clk) disable iff (rst)
    $rose(sref_req) |-> $past(bus_req && bus_ack)); // R5

  AST_SREF_WAIT: assert property (@(posedge clk) disable iff (rst)
    (sref_req && !sref_ack && !wdt_q) |=> (sref_req && !int_rst[0])); // R5

  AST_RST_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(int_rst[0]) |-> $past((sref_req && sref_ack) || wdt_q)); // R6

  AST_PIN_PAIR: assert property (@(posedge clk) disable iff (rst)
    (rst_out_n == !int_rst[0]) && ((&int_rst) || !(|int_rst))); // R8

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_req, sref_req, int_rst[0]})); // R10

  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cause)); // R11

  AST_CAUSE_KEPT: assert property (@(posedge clk) disable iff (rst)
    $fell(int_rst[0]) |-> $stable(cause)); // R11

endmodule

bind rst_seq_ctrl rst_seq_chk #(.NUM_RST(NUM_RST)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wdt_expire (wdt_expire),
  .wdt_rst_en (wdt_rst_en),
  .wdt_tmr_en (wdt_tmr_en),
  .pmode      (pmode),
  .bus_ack    (bus_ack),
  .sref_ack   (sref_ack),
  .bus_req    (bus_req),
  .sref_req   (sref_req),
  .int_rst    (int_rst),
  .rst_out_n  (rst_out_n),
  .cause      (cause)
);

// File: tb/sim_rst_seq_ctrl.sv
module sim_rst_seq_ctrl;

  localparam int NUM_RST = 4;
  localparam int CNT_W   = 16;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               wdt_expire = 1'b0;
  logic               wdt_rst_en = 1'b1;
  logic               wdt_tmr_en = 1'b1;
  logic               swrst_wr = 1'b0;
  logic               swrst_wdata = 1'b0;
  logic               stab_wr = 1'b0;
  logic [CNT_W-1:0]   stab_wdata = '0;
  logic [1:0]         pmode = 2'd0;
  logic               bus_ack = 1'b0;
  logic               sref_ack = 1'b0;
  logic               bus_req;
  logic               sref_req;
  logic [NUM_RST-1:0] int_rst;
  logic               rst_out_n;
  logic [1:0]         cause;
  logic [CNT_W-1:0]   reload;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rst_seq_ctrl #(.NUM_RST(NUM_RST), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .wdt_expire(wdt_expire), .wdt_rst_en(wdt_rst_en),
    .wdt_tmr_en(wdt_tmr_en), .swrst_wr(swrst_wr), .swrst_wdata(swrst_wdata),
    .stab_wr(stab_wr), .stab_wdata(stab_wdata), .pmode(pmode),
    .bus_ack(bus_ack), .sref_ack(sref_ack), .bus_req(bus_req),
    .sref_req(sref_req), .int_rst(int_rst), .rst_out_n(rst_out_n),
    .cause(cause), .reload(reload)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_reload(input int v);
    stab_wr = 1'b1; stab_wdata = CNT_W'(v);
    tick();
    stab_wr = 1'b0;
    chk(reload == CNT_W'(v), "R9 reload write", int'(reload), v);
  endtask

  // count asserted cycles; optionally retrigger both sources mid-reset
  task automatic measure(input int exp, input bit inject, input string req);
    int n = 0;
    bit pin_ok = 1'b1;
    while (int_rst[0] === 1'b1 && n < 70000) begin
      if (rst_out_n !== 1'b0 || int_rst !== {NUM_RST{1'b1}}) pin_ok = 1'b0;
      if (inject && n == 1) begin
        wdt_expire = 1'b1; swrst_wr = 1'b1; swrst_wdata = 1'b1;
      end
      tick();
      wdt_expire = 1'b0; swrst_wr = 1'b0;
      n++;
    end
    chk(n == exp, req, n, exp);
    chk(pin_ok && rst_out_n === 1'b1 && int_rst == '0, "R8 pin pairing",
        int'(rst_out_n), 1);
  endtask

  task automatic wdt_pulse();
    wdt_expire = 1'b1;
    tick();
    wdt_expire = 1'b0;
  endtask

  task automatic sw_write(input bit d);
    swrst_wr = 1'b1; swrst_wdata = d;
    tick();
    swrst_wr = 1'b0; swrst_wdata = 1'b0;
  endtask

  task automatic quiet(input string req);
    bit ok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      if (int_rst[0] || bus_req || sref_req || !rst_out_n) ok = 1'b0;
      tick();
    end
    chk(ok, req, int'(int_rst[0]), 0);
  endtask

  // full software handshake, with ack delays
  task automatic sw_full(input int rl, input int dly);
    sw_write(1'b1);
    chk(bus_req && !int_rst[0], "R4 bus_req raised", int'(bus_req), 1);
    for (int k = 0; k < dly; k++) tick();
    chk(bus_req && !sref_req && !int_rst[0] && rst_out_n, "R4 waits for bus_ack",
        int'(bus_req), 1);
    bus_ack = 1'b1; tick(); bus_ack = 1'b0;
    chk(!bus_req && sref_req && !int_rst[0], "R5 sref_req after ack",
        int'(sref_req), 1);
    for (int k = 0; k < dly; k++) tick();
    chk(sref_req && !int_rst[0], "R5 waits for sref_ack", int'(sref_req), 1);
    sref_ack = 1'b1; tick(); sref_ack = 1'b0;
    chk(!sref_req && int_rst[0], "R6 reset after sref_ack", int'(int_rst[0]), 1);
    chk(cause == 2'b10, "R11 cause software", int'(cause), 2);
    measure(rl + 1, 1'b0, "R6 software reset length");
    chk(cause == 2'b10, "R11 cause kept", int'(cause), 2);
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog timeout act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    tick();
    chk(!bus_req && !sref_req && int_rst == '0 && rst_out_n, "reset state",
        int'(int_rst), 0);
    chk(cause == 2'b00, "R11 cause after rst", int'(cause), 0);
    chk(reload == 16'd8, "R9 reload reset value", int'(reload), 8);

    // R9: default reload gives 9 cycles
    wdt_pulse();
    chk(int_rst[0] && cause == 2'b01, "R7 watchdog immediate", int'(int_rst[0]), 1);
    measure(9, 1'b0, "R9 default length");

    // R6 R7: sweep reload values for both sources
    for (int rl = 0; rl < 6; rl++) begin
      set_reload(rl);
      wdt_pulse();
      chk(int_rst[0] == 1'b1, "R7 watchdog asserts next cycle", int'(int_rst[0]), 1);
      measure(rl + 1, 1'b0, "R7 watchdog reset length");
      sw_full(rl, rl % 3);
    end

    // R1: enable bit combinations
    set_reload(2);
    for (int e = 0; e < 4; e++) begin
      wdt_rst_en = e[1]; wdt_tmr_en = e[0];
      wdt_pulse();
      if (e == 3) begin
        chk(int_rst[0] == 1'b1, "R1 both enables", int'(int_rst[0]), 1);
        measure(3, 1'b0, "R1 length");
      end else begin
        chk(int_rst[0] == 1'b0, "R1 enable missing", int'(int_rst[0]), 0);
        quiet("R1 no reset");
      end
    end

    // R2: watchdog across power modes
    for (int m = 0; m < 4; m++) begin
      pmode = 2'(m);
      wdt_pulse();
      if (m != 3) begin
        chk(int_rst[0] == 1'b1, "R2 mode accepted", int'(int_rst[0]), 1);
        measure(3, 1'b0, "R2 length");
      end else begin
        chk(int_rst[0] == 1'b0, "R2 stop mode ignored", int'(int_rst[0]), 0);
        quiet("R2 stop quiet");
      end
    end

    // R3: software reset across modes and data
    for (int m = 1; m < 4; m++) begin
      pmode = 2'(m);
      sw_write(1'b1);
      chk(!bus_req, "R3 low-power mode ignored", int'(bus_req), 0);
      quiet("R3 quiet");
    end
    pmode = 2'd0;
    sw_write(1'b0);
    chk(!bus_req, "R3 write of zero ignored", int'(bus_req), 0);
    quiet("R3 zero quiet");

    // R10: same cycle priority
    swrst_wr = 1'b1; swrst_wdata = 1'b1; wdt_expire = 1'b1;
    tick();
    swrst_wr = 1'b0; wdt_expire = 1'b0;
    chk(int_rst[0] && !bus_req && cause == 2'b01, "R10 same cycle",
        int'(cause), 1);
    measure(3, 1'b0, "R10 length");
    chk(!bus_req, "R10 no later handshake", int'(bus_req), 0);

    // R10: watchdog during bus wait
    sw_write(1'b1);
    tick();
    wdt_pulse();
    chk(int_rst[0] && !bus_req && cause == 2'b01, "R10 during bus wait",
        int'(int_rst[0]), 1);
    measure(3, 1'b0, "R10 bus wait length");

    // software reset to set cause to software, then watchdog in sref wait
    sw_full(2, 1);
    sw_write(1'b1);
    bus_ack = 1'b1; tick(); bus_ack = 1'b0;
    chk(sref_req, "R5 in sref wait", int'(sref_req), 1);
    wdt_pulse();
    chk(int_rst[0] && !sref_req && cause == 2'b01, "R10 during sref wait",
        int'(cause), 1);
    measure(3, 1'b0, "R10 sref wait length");

    // R12: retrigger during reset
    set_reload(4);
    wdt_pulse();
    measure(5, 1'b1, "R12 retrigger ignored");
    quiet("R12 no phantom sequence");
    chk(cause == 2'b01, "R12 cause unchanged", int'(cause), 1);

    // R9: reload change during quiet applies to next reset
    set_reload(7);
    sw_full(7, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule